// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block fetches the boot-time configuration of a processor core from a serial source. When the power-good input rises, it starts a slow mode clock derived from the system clock. It shifts one configuration bit per mode-clock period from a serial data input into a configuration vector, first bit into bit 0. When the whole stream has been captured, it raises a done flag, stops the mode clock and freezes the vector until power-good falls.

Three results are decoded from the captured vector. The first is the endianness, formed jointly from a mode bit and an external strap pin. The second is a two-bit drive-rate select, whose raw field has a non-monotonic encoding and is re-coded here into a monotonic level. The third is an error flag, raised when any of the mandatory-one mode bits reads as zero. The external source changes its data on the rising mode-clock edge. The loader samples that data in the last system-clock cycle of each period, so the source gets nearly the whole period to set up.

Top module: `bootmode_loader`

## Requirements
- R1: While loading, `mode_clk_o` has a period of exactly `MCLK_DIV` system clocks (default 256). It is high for the first half and low for the second. The first high phase starts on the first clock edge at which `pwr_ok_i` is seen high. The clock is low while `pwr_ok_i` is low.
- R2: Bit k of the stream is sampled at the (k+1)·`MCLK_DIV`-th clock edge after the start edge, which is the last system-clock cycle of mode period k. A value that changes earlier in the period and settles at least 4 clocks before that edge is captured correctly.
- R3: The stream is taken first bit first: the bit sampled in mode period k ends up in `mode_vec_o[k]`.
- R4: `load_done_o` rises on the edge that samples the last of the `MODE_BITS` bits (default 256). From then on `mode_clk_o` stays low.
- R5: Once done, and while `pwr_ok_i` stays high, the vector and the done flag hold, and `mode_dat_i` has no effect.
- R6: A low `pwr_ok_i` at any time clears the vector, the bit counter and the done flag on the next edge. Raising it again restarts a full load from bit 0.
- R7: `big_endian_o` is `mode_vec_o[8] | endian_pin_i` when done, and `endian_pin_i` before done.
- R8: `drive_rate_o` is 0 before done. When done, it re-codes raw field {bit14,bit13} as follows: 2'b10 gives 3 (full rate), 2'b11 gives 2 (83%), 2'b00 gives 1 (67%) and 2'b01 gives 0 (50%).
- R9: `mode_err_o` is high only when done and at least one of mode bits 20, 33 and 37 is 0.
- R10: While `rst_ni` is low, the mode clock, vector, done, rate and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power-good; high starts and holds a load, low clears it |
| mode_dat_i | input | 1 | Serial mode data |
| endian_pin_i | input | 1 | External endianness strap |
| mode_clk_o | output | 1 | Divided mode clock |
| mode_vec_o | output | MODE_BITS | Captured configuration vector |
| load_done_o | output | 1 | Stream fully captured |
| big_endian_o | output | 1 | Resolved endianness |
| drive_rate_o | output | 2 | Monotonic output drive-rate level |
| mode_err_o | output | 1 | A mandatory-one bit read as zero |

## Verification
The loads use random streams with fixed seeds. The rate field is stepped through all four raw codes, which separates a correct re-coding from a plain copy or a bit swap. The endian bit and the strap pin are tried in all combinations, which separates OR from either input alone. Streams with the mandatory bits all set are mixed with streams that clear exactly one of them. Some loads drive the inverted value for most of each period and the true value only in the last few clocks, which shows that sampling happens at the end of the period. A load aborted by a power-good drop, followed by a clean reload, checks the clearing and the restart from bit 0. Data wiggled after done checks the freeze.

// File: rtl/bootmode_pkg.sv
package bootmode_pkg;
  localparam int unsigned ENDIAN_BIT = 8;
  localparam int unsigned RATE_LSB   = 13;
  localparam int unsigned NUM_REQ    = 3;
  localparam int unsigned REQ_BITS [NUM_REQ] = '{20, 33, 37};
  localparam int unsigned MIN_BITS   = 38;

  typedef enum logic [1:0] {
    RATE_50  = 2'd0,
    RATE_67  = 2'd1,
    RATE_83  = 2'd2,
    RATE_100 = 2'd3
  } drive_rate_e;

  // raw field is non-monotonic; map to a monotonic level
  function automatic drive_rate_e rate_decode(input logic [1:0] raw);
    case (raw)
      2'b10:   return RATE_100;
      2'b11:   return RATE_83;
      2'b00:   return RATE_67;
      default: return RATE_50;
    endcase
  endfunction
endpackage

// File: rtl/bootmode_clkdiv.sv
module bootmode_clkdiv #(
  parameter int unsigned MCLK_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic stop_i,
  output logic tick_o,
  output logic mode_clk_o
);
  localparam int unsigned CW = (MCLK_DIV > 2) ? $clog2(MCLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(MCLK_DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(MCLK_DIV / 2);

  logic [CW-1:0] div_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      run_q <= 1'b0;
    end else if (!pwr_ok_i || stop_i) begin
      div_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign tick_o     = run_q && (div_q == LAST);
  assign mode_clk_o = run_q && (div_q < HALF);
endmodule

// File: rtl/bootmode_shifter.sv
module bootmode_shifter #(
  parameter int unsigned MODE_BITS = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_ok_i,
  input  logic                 tick_i,
  input  logic                 dat_i,
  output logic [MODE_BITS-1:0] vec_o,
  output logic                 last_o,
  output logic                 done_o
);
  localparam int unsigned CW = $clog2(MODE_BITS);
  localparam logic [CW-1:0] LAST = CW'(MODE_BITS - 1);

  logic [CW-1:0]        cnt_q;
  logic [MODE_BITS-1:0] vec_q;
  logic                 done_q;

  assign last_o = tick_i && !done_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vec_q  <= '0;
      done_q <= 1'b0;
    end else if (!pwr_ok_i) begin
      cnt_q  <= '0;
      vec_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      // first bit lands in bit 0 after the final shift
      vec_q <= {dat_i, vec_q[MODE_BITS-1:1]};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_q <= 1'b1;
    end
  end

  assign vec_o  = vec_q;
  assign done_o = done_q;
endmodule

// File: rtl/bootmode_decode.sv
module bootmode_decode
  import bootmode_pkg::*;
#(
  parameter int unsigned MODE_BITS = 256
) (
  input  logic [MODE_BITS-1:0] vec_i,
  input  logic                 done_i,
  input  logic                 pin_i,
  output logic                 big_endian_o,
  output logic [1:0]           rate_o,
  output logic                 err_o
);
  logic [NUM_REQ-1:0] req_ok;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assign req_ok[g] = vec_i[REQ_BITS[g]];
  end

  always_comb begin
    big_endian_o = pin_i;
    rate_o       = 2'd0;
    err_o        = 1'b0;
    if (done_i) begin
      big_endian_o = pin_i | vec_i[ENDIAN_BIT];
      rate_o       = rate_decode(vec_i[RATE_LSB+1:RATE_LSB]);
      err_o        = ~&req_ok;
    end
  end
endmodule

// File: rtl/bootmode_loader.sv
module bootmode_loader #(
  parameter int unsigned MCLK_DIV  = 256,
  parameter int unsigned MODE_BITS = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_ok_i,
  input  logic                 mode_dat_i,
  input  logic                 endian_pin_i,
  output logic                 mode_clk_o,
  output logic [MODE_BITS-1:0] mode_vec_o,
  output logic                 load_done_o,
  output logic                 big_endian_o,
  output logic [1:0]           drive_rate_o,
  output logic                 mode_err_o
);
  logic tick, last, done;

  bootmode_clkdiv #(.MCLK_DIV(MCLK_DIV)) u_clkdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_ok_i   (pwr_ok_i),
    .stop_i     (done | last),
    .tick_o     (tick),
    .mode_clk_o (mode_clk_o)
  );

  bootmode_shifter #(.MODE_BITS(MODE_BITS)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .tick_i   (tick),
    .dat_i    (mode_dat_i),
    .vec_o    (mode_vec_o),
    .last_o   (last),
    .done_o   (done)
  );

  bootmode_decode #(.MODE_BITS(MODE_BITS)) u_decode (
    .vec_i        (mode_vec_o),
    .done_i       (done),
    .pin_i        (endian_pin_i),
    .big_endian_o (big_endian_o),
    .rate_o       (drive_rate_o),
    .err_o        (mode_err_o)
  );

  assign load_done_o = done;
endmodule

// File: rtl/bootmode_loader_chk.sv
module bootmode_loader_chk #(
  parameter int unsigned MODE_BITS = 256
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pwr_ok_i,
  input logic                 endian_pin_i,
  input logic                 mode_clk_o,
  input logic [MODE_BITS-1:0] mode_vec_o,
  input logic                 load_done_o,
  input logic                 big_endian_o,
  input logic [1:0]           drive_rate_o,
  input logic                 mode_err_o
);
  AST_CLR_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (mode_vec_o == '0) && !load_done_o); // R6
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !mode_clk_o); // R1
  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o && pwr_ok_i |=> load_done_o && $stable(mode_vec_o)); // R5
  AST_CLK_QUIET_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> !mode_clk_o); // R4
  AST_ENDIAN_PRE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_done_o |-> big_endian_o == endian_pin_i); // R7
  AST_RATE_PRE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_done_o |-> drive_rate_o == 2'd0); // R8
  AST_ERR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> load_done_o); // R9
endmodule

bind bootmode_loader bootmode_loader_chk #(.MODE_BITS(MODE_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_ok_i     (pwr_ok_i),
  .endian_pin_i (endian_pin_i),
  .mode_clk_o   (mode_clk_o),
  .mode_vec_o   (mode_vec_o),
  .load_done_o  (load_done_o),
  .big_endian_o (big_endian_o),
  .drive_rate_o (drive_rate_o),
  .mode_err_o   (mode_err_o)
);

// File: tb/bootmode_loader_bench.sv
module bootmode_loader_bench;
  localparam int unsigned DIV  = 16;
  localparam int unsigned NB   = 40;
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned SU   = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pwr_ok_i = 1'b0;
  logic          mode_dat_i = 1'b0;
  logic          endian_pin_i = 1'b0;
  logic          mode_clk_o;
  logic [NB-1:0] mode_vec_o;
  logic          load_done_o;
  logic          big_endian_o;
  logic [1:0]    drive_rate_o;
  logic          mode_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  bootmode_loader #(.MCLK_DIV(DIV), .MODE_BITS(NB)) u_bootmode_loader (
    .clk_i, .rst_ni, .pwr_ok_i, .mode_dat_i, .endian_pin_i,
    .mode_clk_o, .mode_vec_o, .load_done_o, .big_endian_o,
    .drive_rate_o, .mode_err_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rate(input logic [NB-1:0] v);
    case ({v[14], v[13]})
      2'b10:   return 2'd3;
      2'b11:   return 2'd2;
      2'b00:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic exp_err(input logic [NB-1:0] v);
    return !(v[20] && v[33] && v[37]);
  endfunction

  // abort >= 0 drops power-good during period 'abort'
  task automatic run_load(input logic [NB-1:0] v, input bit late, input int abort);
    bit clk_ok = 1;
    @(negedge clk_i);
    pwr_ok_i   = 1'b1;
    mode_dat_i = late ? ~v[0] : v[0];
    @(posedge clk_i);
    for (int k = 0; k < NB; k++) begin
      for (int j = 1; j <= DIV; j++) begin
        @(negedge clk_i);
        if (j == 1) mode_dat_i = late ? ~v[k] : v[k];
        if (late && j == DIV - SU + 1) mode_dat_i = v[k];
        if (k < 2 && mode_clk_o !== (j <= HALF)) clk_ok = 0;
        if (k == abort && j == HALF) begin
          pwr_ok_i = 1'b0;
          @(negedge clk_i);
          chk(mode_vec_o == '0 && !load_done_o && !mode_clk_o, "R6 clear on drop",
              {mode_vec_o, load_done_o}, 0);
          return;
        end
        if (k == NB - 1 && j == DIV)
          chk(!load_done_o, "R4 not done before last sample", load_done_o, 0);
        @(posedge clk_i);
      end
    end
    chk(clk_ok, "R1 mode clock period and phase", clk_ok, 1);
    @(negedge clk_i);
    chk(load_done_o, "R4 done after last sample", load_done_o, 1);
    chk(mode_vec_o == v, late ? "R2 late sampling" : "R3 bit order",
        mode_vec_o, v);
    chk(big_endian_o == (v[8] | endian_pin_i), "R7 endianness", big_endian_o,
        v[8] | endian_pin_i);
    chk(drive_rate_o == exp_rate(v), "R8 rate decode", drive_rate_o, exp_rate(v));
    chk(mode_err_o == exp_err(v), "R9 mandatory bits", mode_err_o, exp_err(v));
    clk_ok = 1;
    for (int j = 0; j < 3 * DIV; j++) begin
      mode_dat_i = $urandom_range(0, 1);
      @(negedge clk_i);
      if (mode_clk_o) clk_ok = 0;
    end
    chk(clk_ok, "R4 mode clock stopped", clk_ok, 1);
    chk(mode_vec_o == v && load_done_o, "R5 frozen after done", mode_vec_o, v);
    pwr_ok_i = 1'b0;
    @(negedge clk_i);
    chk(mode_vec_o == '0 && !load_done_o && drive_rate_o == 0 && !mode_err_o,
        "R6 clear after drop", mode_vec_o, 0);
  endtask

  initial begin
    logic [NB-1:0] v;
    void'($urandom(32'd1234));
    #3;
    chk(!mode_clk_o && mode_vec_o == '0 && !load_done_o && drive_rate_o == 0 &&
        !mode_err_o, "R10 reset state", mode_vec_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mode_clk_o && !load_done_o, "R1 idle without power-good", mode_clk_o, 0);

    v = {$urandom, $urandom};
    run_load(v, 1'b0, 7);
    for (int i = 0; i < 12; i++) begin
      v = {$urandom, $urandom};
      v[14:13] = 2'(i % 4);
      v[8] = i[1];
      endian_pin_i = i[2];
      v[20] = 1'b1; v[33] = 1'b1; v[37] = 1'b1;
      if (i == 5) v[20] = 1'b0;
      if (i == 8) v[33] = 1'b0;
      if (i == 11) v[37] = 1'b0;
      run_load(v, (i % 3) == 0, -1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule